// File: doc/BRIEF.md
# K1/K2 Protection Byte Inserter with Automatic Line RDI

This block sits on the transmit byte stream of a SONET/SDH line and rewrites the two automatic-protection-switching bytes (K1 and K2) as they pass. All other bytes leave unchanged one clock after they enter. Two position strobes, one for K1 and one for K2, mark the byte positions. A start-of-frame pulse marks the first byte of each frame. The block sees one byte per clock.

A 16-bit programmed word supplies the replacement bits. One insert control covers K1 together with K2[7:3]. A second insert control covers the K2 mode bits, K2[2:0]. K2[2:0] can take one of three values:

- the line remote-defect code, 110, which wins over the other two;
- the programmed bits;
- the incoming bits.

The defect code is sent automatically while any enabled far-end defect reported by the opposite-direction receiver is present. It then stays on for at least a fixed number of frames. Every control and defect input is sampled only on the start-of-frame pulse, so the inserted bytes never change partway through a frame.

Top module: `aps_byte_inserter`

## Requirements
- R1: Every byte not marked as K1 or K2 appears on `data_out` unchanged, exactly one clock after it is presented on `data_in`.
- R2: When the sampled `aps_ins` is 1, the K1 byte becomes `prog_k1k2[15:8]` and K2[7:3] becomes `prog_k1k2[7:3]`. When it is 0, those bits pass through from `data_in`.
- R3: When no defect indication is active and the sampled `mode_ins` is 1, K2[2:0] becomes `prog_k1k2[2:0]`. When no defect indication is active and `mode_ins` is 0, the incoming K2[2:0] pass through.
- R4: While the defect indication is active, K2[2:0] is 3'b110, whatever `mode_ins` is. K1 and K2[7:3] still follow R2.
- R5: A frame triggers the defect indication only if, at its start-of-frame pulse, `rdi_auto_en` is 1 and `defect & defect_en` is nonzero. The defect bit order is [0] far-end AIS-L, [1] signal fail, [2] loss of frame, [3] loss of signal, [4] section trace mismatch. A defect whose enable is 0 has no effect.
- R6: A triggering frame starts the indication, or restarts it during a hold. The indication then covers that frame and the following frames, HOLD_FRAMES frames in total (default 20). It clears at the first start of frame after that window in which no trigger is present.
- R7: A start of frame with `rdi_auto_en` at 0 ends any indication at once, starting with that frame.
- R8: Changes to `prog_k1k2`, the insert controls, the auto enable, the defects or the defect enables between two start-of-frame pulses do not affect the frame in progress.
- R9: While `rst` is high, `data_out` is 0 at the next clock and the defect indication is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse, high on the first byte of a frame |
| k1_pos | input | 1 | Marks the current byte as K1 |
| k2_pos | input | 1 | Marks the current byte as K2 |
| data_in | input | 8 | Incoming transmit byte |
| prog_k1k2 | input | 16 | Programmed K1 (bits 15:8) and K2 (bits 7:0) value |
| aps_ins | input | 1 | Insert K1 and K2[7:3] from the programmed value |
| mode_ins | input | 1 | Insert K2[2:0] from the programmed value |
| rdi_auto_en | input | 1 | Allow automatic line RDI insertion |
| defect | input | 5 | Opposite-direction defect indications |
| defect_en | input | 5 | Per-defect enables for RDI triggering |
| data_out | output | 8 | Outgoing transmit byte, one clock latency |

## Verification
The stream carries random bytes, so pass-through is told apart from any constant value. Each insert control is toggled on its own, which separates K1/K2[7:3] replacement from mode-bit replacement.

A one-frame defect pulse measures the exact hold length against both the programmed and the pass-through fallback. The following cases show that the trigger gating and the timer restart are distinct mechanisms:

- a defect with its enable clear;
- a defect with auto off;
- a retrigger late in a hold;
- auto cleared during a hold.

Mid-frame changes to the programmed word, the insert controls, the auto enable, the defects and the defect enables show that sampling happens only at the start of a frame.

// File: rtl/aps_ins_pkg.sv
package aps_ins_pkg;

    localparam int BYTE_W      = 8;
    localparam int NUM_DEFECTS = 5;
    localparam int PROG_W      = 2 * BYTE_W;
    localparam int MODE_W      = 3;
    localparam logic [MODE_W-1:0] RDI_LINE_CODE = 3'b110;

    // Bit positions of the defect vector
    typedef enum int {
        DEF_FAR_AIS = 0,
        DEF_SIG_FAIL = 1,
        DEF_LOF = 2,
        DEF_LOS = 3,
        DEF_TRACE_MISMATCH = 4
    } defect_idx_e;

    // Controls captured once per frame
    typedef struct packed {
        logic [PROG_W-1:0] prog;
        logic              aps_ins;
        logic              mode_ins;
    } frame_ctrl_t;

    typedef enum logic [1:0] {
        K2SRC_PASS = 2'd0,
        K2SRC_PROG = 2'd1,
        K2SRC_RDI  = 2'd2
    } k2_src_e;

    function automatic k2_src_e pick_k2_src(input logic rdi_on, input logic mode_ins);
        if (rdi_on)        return K2SRC_RDI;
        else if (mode_ins) return K2SRC_PROG;
        else               return K2SRC_PASS;
    endfunction

    function automatic logic [BYTE_W-1:0] build_k1(input frame_ctrl_t c,
                                                   input logic [BYTE_W-1:0] din);
        return c.aps_ins ? c.prog[PROG_W-1:BYTE_W] : din;
    endfunction

    function automatic logic [BYTE_W-1:0] build_k2(input frame_ctrl_t c,
                                                   input k2_src_e src,
                                                   input logic [BYTE_W-1:0] din);
        logic [BYTE_W-1:0] r;
        r[BYTE_W-1:MODE_W] = c.aps_ins ? c.prog[BYTE_W-1:MODE_W] : din[BYTE_W-1:MODE_W];
        case (src)
            K2SRC_RDI:  r[MODE_W-1:0] = RDI_LINE_CODE;
            K2SRC_PROG: r[MODE_W-1:0] = c.prog[MODE_W-1:0];
            default:    r[MODE_W-1:0] = din[MODE_W-1:0];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aps_ctrl_sampler.sv
module aps_ctrl_sampler
    import aps_ins_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sof,
    input  logic [PROG_W-1:0]      prog_k1k2,
    input  logic                   aps_ins,
    input  logic                   mode_ins,
    input  logic [NUM_DEFECTS-1:0] defect,
    input  logic [NUM_DEFECTS-1:0] defect_en,
    input  logic                   rdi_auto_en,
    output frame_ctrl_t            ctrl_q,
    output logic                   trig
);

    logic [NUM_DEFECTS-1:0] masked;

    generate
        for (genvar i = 0; i < NUM_DEFECTS; i++) begin : g_mask
            assign masked[i] = defect[i] & defect_en[i];
        end
    endgenerate

    // Trigger is presented with sof; the timer latches it on the same edge
    assign trig = rdi_auto_en & (|masked);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (sof) begin
            ctrl_q.prog     <= prog_k1k2;
            ctrl_q.aps_ins  <= aps_ins;
            ctrl_q.mode_ins <= mode_ins;
        end
    end

    a_r8_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
        !sof |=> $stable(ctrl_q));

endmodule

// File: rtl/rdi_hold_timer.sv
module rdi_hold_timer #(
    parameter int HOLD_FRAMES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic sof,
    input  logic trig,
    input  logic auto_en,
    output logic rdi_on
);

    localparam int CNT_W = $clog2(HOLD_FRAMES + 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_FRAMES);

    logic [CNT_W-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (sof) begin
            if (!auto_en)
                hold_cnt <= '0;
            else if (trig)
                hold_cnt <= HOLD_LOAD;
            else if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign rdi_on = (hold_cnt != '0);

    a_r6_only_at_frame: assert property (@(posedge clk) disable iff (rst)
        !sof |=> $stable(hold_cnt));
    a_r6_restart_full: assert property (@(posedge clk) disable iff (rst)
        (sof && trig && auto_en) |=> (hold_cnt == HOLD_LOAD));
    a_r7_auto_release: assert property (@(posedge clk) disable iff (rst)
        (sof && !auto_en) |=> !rdi_on);

endmodule

// File: rtl/k_byte_merge.sv
module k_byte_merge
    import aps_ins_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              k1_pos,
    input  logic              k2_pos,
    input  logic [BYTE_W-1:0] data_in,
    input  frame_ctrl_t       ctrl_q,
    input  logic              rdi_on,
    output logic [BYTE_W-1:0] data_out
);

    k2_src_e           src;
    logic [BYTE_W-1:0] next_byte;

    always_comb begin
        src = pick_k2_src(rdi_on, ctrl_q.mode_ins);
        if (k1_pos)
            next_byte = build_k1(ctrl_q, data_in);
        else if (k2_pos)
            next_byte = build_k2(ctrl_q, src, data_in);
        else
            next_byte = data_in;
    end

    always_ff @(posedge clk) begin
        if (rst) data_out <= '0;
        else     data_out <= next_byte;
    end

    a_r1_passthru: assert property (@(posedge clk) disable iff (rst)
        (!k1_pos && !k2_pos) |=> (data_out == $past(data_in)));
    a_r2_k1_prog: assert property (@(posedge clk) disable iff (rst)
        (k1_pos && ctrl_q.aps_ins) |=> (data_out == $past(ctrl_q.prog[PROG_W-1:BYTE_W])));

endmodule

// File: rtl/aps_byte_inserter.sv
module aps_byte_inserter
    import aps_ins_pkg::*;
#(
    parameter int HOLD_FRAMES = 20
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sof,
    input  logic                   k1_pos,
    input  logic                   k2_pos,
    input  logic [BYTE_W-1:0]      data_in,
    input  logic [PROG_W-1:0]      prog_k1k2,
    input  logic                   aps_ins,
    input  logic                   mode_ins,
    input  logic                   rdi_auto_en,
    input  logic [NUM_DEFECTS-1:0] defect,
    input  logic [NUM_DEFECTS-1:0] defect_en,
    output logic [BYTE_W-1:0]      data_out
);

    frame_ctrl_t ctrl_q;
    logic        trig;
    logic        rdi_on;

    aps_ctrl_sampler u_sampler (
        .clk         (clk),
        .rst         (rst),
        .sof         (sof),
        .prog_k1k2   (prog_k1k2),
        .aps_ins     (aps_ins),
        .mode_ins    (mode_ins),
        .defect      (defect),
        .defect_en   (defect_en),
        .rdi_auto_en (rdi_auto_en),
        .ctrl_q      (ctrl_q),
        .trig        (trig)
    );

    rdi_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .sof     (sof),
        .trig    (trig),
        .auto_en (rdi_auto_en),
        .rdi_on  (rdi_on)
    );

    k_byte_merge u_merge (
        .clk      (clk),
        .rst      (rst),
        .k1_pos   (k1_pos),
        .k2_pos   (k2_pos),
        .data_in  (data_in),
        .ctrl_q   (ctrl_q),
        .rdi_on   (rdi_on),
        .data_out (data_out)
    );

    a_r4_rdi_code: assert property (@(posedge clk) disable iff (rst)
        (k2_pos && rdi_on) |=> (data_out[MODE_W-1:0] == RDI_LINE_CODE));
    a_r9_reset_out: assert property (@(posedge clk)
        rst |=> (data_out == '0));

endmodule

// File: tb/sim_aps_byte_inserter.sv
`timescale 1ns/1ps
module sim_aps_byte_inserter;

    localparam int HOLD = 20;
    localparam int FLEN = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof = 1'b0, k1_pos = 1'b0, k2_pos = 1'b0;
    logic [7:0]  data_in = '0;
    logic [15:0] prog_k1k2 = '0;
    logic        aps_ins = 1'b0, mode_ins = 1'b0, rdi_auto_en = 1'b0;
    logic [4:0]  defect = '0, defect_en = '0;
    logic [7:0]  data_out;

    int total = 0, bad = 0;
    bit finished = 0;

    // Reference state
    logic [15:0] m_prog = '0;
    bit          m_aps = 0, m_mode = 0;
    int          m_cnt = 0;
    logic [7:0]  exp_q;
    bit          have_exp = 0;
    string       exp_tag = "R1";

    always #2 clk = ~clk;

    aps_byte_inserter #(.HOLD_FRAMES(HOLD)) u0 (
        .clk(clk), .rst(rst), .sof(sof), .k1_pos(k1_pos), .k2_pos(k2_pos),
        .data_in(data_in), .prog_k1k2(prog_k1k2), .aps_ins(aps_ins),
        .mode_ins(mode_ins), .rdi_auto_en(rdi_auto_en), .defect(defect),
        .defect_en(defect_en), .data_out(data_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: data_out=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // One frame; glitch=1 disturbs every control input mid-frame (R8)
    task automatic run_frame(input string tag, input bit glitch);
        logic [15:0] s_prog;
        bit s_aps, s_mode, s_auto;
        logic [4:0] s_def, s_en;
        s_prog = '0; s_aps = 0; s_mode = 0; s_auto = 0; s_def = '0; s_en = '0;
        for (int b = 0; b < FLEN; b++) begin
            @(negedge clk);
            if (have_exp) check(exp_tag, data_out, exp_q);
            if (glitch && b == 2) begin
                s_prog = prog_k1k2; s_aps = aps_ins; s_mode = mode_ins;
                s_auto = rdi_auto_en; s_def = defect; s_en = defect_en;
                prog_k1k2 = ~prog_k1k2; aps_ins = ~aps_ins; mode_ins = ~mode_ins;
                rdi_auto_en = ~rdi_auto_en; defect = 5'h1f; defect_en = 5'h1f;
            end
            if (glitch && b == 6) begin
                prog_k1k2 = s_prog; aps_ins = s_aps; mode_ins = s_mode;
                rdi_auto_en = s_auto; defect = s_def; defect_en = s_en;
            end
            sof = (b == 0); k1_pos = (b == 3); k2_pos = (b == 4);
            data_in = 8'($urandom);
            if (sof) begin
                m_prog = prog_k1k2; m_aps = aps_ins; m_mode = mode_ins;
                if (!rdi_auto_en)                      m_cnt = 0;
                else if ((defect & defect_en) != '0)   m_cnt = HOLD;
                else if (m_cnt > 0)                    m_cnt--;
            end
            if (k1_pos) begin
                exp_q = m_aps ? m_prog[15:8] : data_in;
                exp_tag = {tag, " K1 (R2)"};
            end else if (k2_pos) begin
                exp_q[7:3] = m_aps ? m_prog[7:3] : data_in[7:3];
                if (m_cnt > 0)   exp_q[2:0] = 3'b110;
                else if (m_mode) exp_q[2:0] = m_prog[2:0];
                else             exp_q[2:0] = data_in[2:0];
                exp_tag = {tag, " K2"};
            end else begin
                exp_q = data_in;
                exp_tag = {tag, " other byte (R1)"};
            end
            have_exp = 1;
        end
    endtask

    initial begin : watchdog
        #400000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        data_in = 8'hA5;
        @(negedge clk);
        check("R9 reset output", data_out, 8'h00);
        rst = 1'b0;

        // R9: no indication right after reset, pass-through everywhere (R1, R3)
        for (int f = 0; f < 3; f++) run_frame("R9 R1 R3 after reset", 0);

        // R2: upper insertion only
        prog_k1k2 = 16'h3C5A; aps_ins = 1;
        for (int f = 0; f < 3; f++) run_frame("R2 aps insert", 0);

        // R3: mode bits only, then both
        aps_ins = 0; mode_ins = 1; prog_k1k2 = 16'hC3A1;
        for (int f = 0; f < 3; f++) run_frame("R3 mode insert", 0);
        aps_ins = 1;
        for (int f = 0; f < 2; f++) run_frame("R2 R3 both insert", 0);

        // R4/R6: one-frame LOS pulse, hold over programmed value
        rdi_auto_en = 1; defect_en = 5'h1f; defect = 5'b01000;
        run_frame("R4 R6 trigger", 0);
        defect = '0;
        for (int f = 0; f < HOLD + 3; f++) run_frame("R4 R6 hold/release programmed", 0);

        // R6 over pass-through, with retrigger late in the hold
        mode_ins = 0; aps_ins = 0; defect = 5'b00001;
        run_frame("R6 trigger AIS", 0);
        defect = '0;
        for (int f = 0; f < HOLD - 3; f++) run_frame("R6 hold passthru", 0);
        defect = 5'b10000;
        run_frame("R6 retrigger TIM", 0);
        defect = '0;
        for (int f = 0; f < HOLD + 2; f++) run_frame("R6 restarted hold", 0);

        // R5: defect with enable clear, and enabled defect with auto off
        mode_ins = 1; prog_k1k2 = 16'h0F03;
        defect = 5'b00110; defect_en = 5'b11001;
        for (int f = 0; f < 3; f++) run_frame("R5 masked defect", 0);
        defect_en = 5'h1f; rdi_auto_en = 0;
        for (int f = 0; f < 3; f++) run_frame("R5 auto off", 0);

        // R7: auto cleared during hold
        rdi_auto_en = 1;
        run_frame("R7 trigger", 0);
        defect = '0;
        for (int f = 0; f < 4; f++) run_frame("R7 holding", 0);
        rdi_auto_en = 0;
        for (int f = 0; f < 3; f++) run_frame("R7 released", 0);

        // R8: mid-frame disturbance of every control
        rdi_auto_en = 1; aps_ins = 1; mode_ins = 1; prog_k1k2 = 16'h9635;
        defect = '0;
        for (int f = 0; f < 4; f++) run_frame("R8 mid-frame change", 1);
        aps_ins = 0; mode_ins = 0;
        for (int f = 0; f < 3; f++) run_frame("R8 mid-frame change no insert", 1);

        @(negedge clk);
        check(exp_tag, data_out, exp_q);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule